// File: doc/BRIEF.md
# Snoop Control Register Block

This block is the register front end of a snoop control unit in a multi-core processor cluster. It occupies a 256-byte window on a simple register bus. Each cycle the bus presents at most one access: a select strobe, a write flag, a byte offset and write data. Reads return data on a registered path one cycle after the request, together with a valid strobe.

The only state it holds is a single enable bit. A read-only configuration word describes the cluster. Its low nibble is the core count minus one. Starting at bit 4 it carries a mask with one bit set for each core present. Both values are derived from the `NUM_CORES` parameter, which ranges from 1 to 4.

A CPU status word and an invalidate-all command word are also decoded. Both read as zero, and writing them changes nothing. Any access to an offset that no register decodes returns zero, has no effect, and raises a one-cycle debug flag.

Top module: `snoop_ctl_regs`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `rd_valid` and `bad_access` are 0. The enable bit resets to 0, so a first read of offset 0x00 returns 0.
- R2: A write to offset 0x00 stores only bit 0 of `wr_data`. A read of offset 0x00 returns that bit in bit 0, with bits 31:1 zero.
- R3: A read of offset 0x04 returns `NUM_CORES - 1` in bits 3:0.
- R4: A read of offset 0x04 returns `(2^NUM_CORES - 1) << 4` in bits 31:4, which is one mask bit per present core, starting at bit 4.
- R5: Reads of offset 0x08 (status) and offset 0x0C (invalidate-all) return zero.
- R6: A write to offset 0x0C is accepted without a flag and leaves the enable bit unchanged.
- R7: A read of any offset other than 0x00, 0x04, 0x08 and 0x0C returns zero. This includes unaligned offsets. A write to such an offset leaves the enable bit unchanged.
- R8: `bad_access` is 1 for exactly the one cycle after an access (read or write) to an unmapped offset, and is 0 after every other cycle.
- R9: `rd_valid` is 1 in the cycle after a read request and 0 otherwise. `rd_data` carries the read value in that cycle and is zero when `rd_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access strobe for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset within the window |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| rd_valid | output | 1 | Read data valid, one cycle after the request |
| bad_access | output | 1 | One-cycle pulse after an unmapped access |

## Verification
The in-line properties are checked on every cycle:

- the one-cycle latency of `rd_valid` (R9);
- the zero upper bits of a control read (R2);
- the exact configuration word (R3, R4);
- the zero status and invalidate reads (R5);
- the rule that only a control write may change the enable bit (R6, R7);
- the bad-access pulse and its absence after mapped or idle cycles (R8).

Only the bench scenarios can show that the stored bit comes back from a later read, and that data patterns with bit 0 clear or set are handled as required. They also show that unaligned and high unmapped offsets read as zero, and that a write to invalidate-all or to a hole leaves a previously written value intact.

// File: rtl/snoop_ctl_pkg.sv
package snoop_ctl_pkg;

    localparam int WIN_AW = 8;

    typedef enum logic [2:0] {
        REG_ENABLE,
        REG_LAYOUT,
        REG_STATUS,
        REG_FLUSH,
        REG_HOLE
    } region_e;

    localparam logic [WIN_AW-1:0] OFS_ENABLE = 8'h00;
    localparam logic [WIN_AW-1:0] OFS_LAYOUT = 8'h04;
    localparam logic [WIN_AW-1:0] OFS_STATUS = 8'h08;
    localparam logic [WIN_AW-1:0] OFS_FLUSH  = 8'h0C;

    // Present-core mask at bit 4 and up, count minus one in the low nibble.
    function automatic logic [31:0] layout_word(input int cores);
        logic [31:0] mask;
        mask = (32'd1 << cores) - 32'd1;
        return (mask << 4) | 32'(cores - 1);
    endfunction

endpackage

// File: rtl/snoop_ctl_decode.sv
module snoop_ctl_decode
    import snoop_ctl_pkg::*;
(
    input  logic [WIN_AW-1:0] addr,
    output region_e           region
);

    always_comb begin
        unique case (addr)
            OFS_ENABLE: region = REG_ENABLE;
            OFS_LAYOUT: region = REG_LAYOUT;
            OFS_STATUS: region = REG_STATUS;
            OFS_FLUSH:  region = REG_FLUSH;
            default:    region = REG_HOLE;
        endcase
    end

endmodule

// File: rtl/snoop_ctl_enable.sv
module snoop_ctl_enable (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic load_val,
    output logic enable
);

    typedef struct packed {
        logic en;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.en = load_val;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign enable = st_q.en;

    // R6 / R7: only a control write may move the enable bit.
    p_enable_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(enable));

endmodule

// File: rtl/snoop_ctl_regs.sv
module snoop_ctl_regs
    import snoop_ctl_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int DATA_W    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [WIN_AW-1:0] bus_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              bad_access
);

    localparam logic [DATA_W-1:0] LAYOUT_VAL = DATA_W'(layout_word(NUM_CORES));

    typedef struct packed {
        logic              vld;
        logic              bad;
        logic [DATA_W-1:0] dat;
    } resp_t;

    region_e region;
    logic    enable;
    logic    enable_load;
    logic    rd_req;

    resp_t rsp_d, rsp_q;

    snoop_ctl_decode u_decode (
        .addr   (bus_addr),
        .region (region)
    );

    assign enable_load = bus_sel && bus_wr && (region == REG_ENABLE);
    assign rd_req      = bus_sel && !bus_wr;

    snoop_ctl_enable u_enable (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (enable_load),
        .load_val (wr_data[0]),
        .enable   (enable)
    );

    always_comb begin
        rsp_d     = '0;
        rsp_d.vld = rd_req;
        rsp_d.bad = bus_sel && (region == REG_HOLE);
        if (rd_req) begin
            unique case (region)
                REG_ENABLE: rsp_d.dat = DATA_W'(enable);
                REG_LAYOUT: rsp_d.dat = LAYOUT_VAL;
                default:    rsp_d.dat = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rd_data    = rsp_q.dat;
    assign rd_valid   = rsp_q.vld;
    assign bad_access = rsp_q.bad;

    p_rd_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr) |=> rd_valid);

    p_rd_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && !bus_wr) |=> (!rd_valid && rd_data == '0));

    p_enable_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_addr == OFS_ENABLE) |=> (rd_data[DATA_W-1:1] == '0));

    p_layout_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_addr == OFS_LAYOUT) |=> (rd_data == LAYOUT_VAL));

    p_zero_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && (bus_addr == OFS_STATUS || bus_addr == OFS_FLUSH))
        |=> (rd_data == '0));

    p_hole_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && region == REG_HOLE) |=> bad_access);

    p_no_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && region == REG_HOLE) |=> !bad_access);

endmodule

// File: tb/snoop_ctl_regs_tb.sv
`timescale 1ns/1ps
module snoop_ctl_regs_tb;

    localparam int NC = 3;
    localparam logic [31:0] CFG_EXP = (((32'd1 << NC) - 32'd1) << 4) | 32'(NC - 1);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        rd_valid;
    logic        bad_access;

    int checks = 0;
    int failures = 0;

    typedef struct {
        logic        vld;
        logic        bad;
        logic [31:0] dat;
        string       req;
    } item_t;

    item_t exp_q[$];

    always #2.5 clk = ~clk;

    snoop_ctl_regs #(.NUM_CORES(NC), .DATA_W(32)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_sel    (bus_sel),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .wr_data    (wr_data),
        .rd_data    (rd_data),
        .rd_valid   (rd_valid),
        .bad_access (bad_access)
    );

    task automatic check(input string req, input logic [33:0] act, input logic [33:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Driver: one access per cycle; the expected response is queued.
    task automatic access(input logic wr, input logic [7:0] a, input logic [31:0] d,
                          input logic [31:0] exp_dat, input logic exp_bad, input string req);
        item_t it;
        @(negedge clk);
        bus_sel  = 1'b1;
        bus_wr   = wr;
        bus_addr = a;
        wr_data  = d;
        it.vld = !wr;
        it.bad = exp_bad;
        it.dat = wr ? 32'h0 : exp_dat;
        it.req = req;
        exp_q.push_back(it);
    endtask

    task automatic idle();
        @(negedge clk);
        bus_sel = 1'b0;
        bus_wr  = 1'b0;
    endtask

    // Monitor: compares each response one time unit after the edge.
    always @(posedge clk) begin
        if (rst_n) begin
            #1;
            if (exp_q.size() > 0) begin
                item_t it;
                it = exp_q.pop_front();
                check(it.req, {rd_valid, bad_access, rd_data}, {it.vld, it.bad, it.dat});
            end else begin
                check("R9/R8 idle", {rd_valid, bad_access, rd_data}, 34'h0);
            end
        end
    end

    initial begin
        #200000;
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset outputs", {rd_valid, bad_access, rd_data}, 34'h0);
        rst_n = 1'b1;
        // R1: first read of the enable bit after reset.
        access(1'b0, 8'h00, 32'h0, 32'h0, 1'b0, "R1 enable after reset");
        // R2: only bit 0 is kept.
        access(1'b1, 8'h00, 32'hFFFF_FFFF, 32'h0, 1'b0, "R2 write all ones");
        access(1'b0, 8'h00, 32'h0, 32'h1, 1'b0, "R2 read back one");
        access(1'b1, 8'h00, 32'hFFFF_FFFE, 32'h0, 1'b0, "R2 write bit0 clear");
        access(1'b0, 8'h00, 32'h0, 32'h0, 1'b0, "R2 read back zero");
        access(1'b1, 8'h00, 32'h0000_0001, 32'h0, 1'b0, "R2 write one");
        // R3 / R4: configuration word.
        access(1'b0, 8'h04, 32'h0, CFG_EXP, 1'b0, "R3 R4 layout word");
        // R5: zero reads.
        access(1'b0, 8'h08, 32'h0, 32'h0, 1'b0, "R5 status read");
        access(1'b0, 8'h0C, 32'h0, 32'h0, 1'b0, "R5 invalidate read");
        // R6: invalidate write changes nothing.
        access(1'b1, 8'h0C, 32'hFFFF_FFFE, 32'h0, 1'b0, "R6 invalidate write");
        access(1'b0, 8'h00, 32'h0, 32'h1, 1'b0, "R6 enable kept");
        // R7 / R8: holes.
        access(1'b0, 8'h01, 32'h0, 32'h0, 1'b1, "R7 R8 unaligned read");
        access(1'b0, 8'h10, 32'h0, 32'h0, 1'b1, "R7 R8 hole read");
        access(1'b0, 8'hFC, 32'h0, 32'h0, 1'b1, "R7 R8 top read");
        access(1'b1, 8'h40, 32'h0, 32'h0, 1'b1, "R7 R8 hole write");
        access(1'b1, 8'h02, 32'h0, 32'h0, 1'b1, "R7 R8 unaligned write");
        access(1'b0, 8'h00, 32'h0, 32'h1, 1'b0, "R7 enable kept");
        // R8: flag drops after a hole access followed by a mapped one.
        access(1'b0, 8'h20, 32'h0, 32'h0, 1'b1, "R8 hole pulse");
        access(1'b0, 8'h04, 32'h0, CFG_EXP, 1'b0, "R8 R9 flag clear, back to back");
        idle();
        idle();
        // R9: a write gives no valid strobe.
        access(1'b1, 8'h00, 32'h0, 32'h0, 1'b0, "R9 write no valid");
        access(1'b0, 8'h00, 32'h0, 32'h0, 1'b0, "R9 read valid");
        idle();
        idle();
        idle();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule